// File: doc/BRIEF.md
# Window-Checked Dual-Path Input Synchronizer

This block is the receive-side front end for a signal that arrives with no timing relation to the receiving logic. It keeps two synchronizers side by side. The direct path samples the registered input as it is. The delayed path samples a copy of that input held back by a fixed number of fast-clock taps. A small detector watches the input during a guard window around each receive edge. The window opens on the setup-start strobe and closes on the hold-end strobe. If the input moves inside that window, the sample the direct path took at that edge is not trusted. For one receive cycle the output then comes from the delayed path, whose copy of the transition lands well clear of the window.

The whole block runs on one fast oversampling clock. The receive clock edge appears as a one-cycle enable, `rx_tick`. The two window strobes are supplied from outside as one-cycle pulses. Choosing the delayed path costs one extra receive cycle of latency for the affected transition. Otherwise the block adds no cost.

Top module: `mwin_sync_front`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the block clears the input register, both synchronizers, the tap chain and all detector state. After reset, `sync_out` reads all zeros and `sel_delayed` reads 0.
- R2: The detector flags a change in any fast-clock cycle where the registered input differs from its value one cycle earlier in at least one bit. A change of a single bit counts.
- R3: The guard window covers every fast-clock cycle from the one in which `win_open` is high through the one in which `win_close` is high, and both of those cycles are included. A change one cycle before `win_open` or one cycle after `win_close` does not count as in-window.
- R4: If a change falls inside the window around receive edge k, `sel_delayed` reads 1 after receive edge k+1 and until receive edge k+2.
- R5: While `sel_delayed` is 1, `sync_out` shows the delayed-path synchronizer. That path sees the input DEPTH fast cycles late, where DEPTH exceeds the window length. `sync_out` therefore holds the value from before the in-window change, never the value the direct path captured. The new value appears after receive edge k+2.
- R6: A change outside every window leaves `sel_delayed` at 0. It reaches `sync_out` through the direct path after the second receive edge that follows the change.
- R7: The record of an in-window change is discarded when the next `win_open` arrives. The per-window decision is taken at `win_close`, so `sel_delayed` returns to 0 one receive cycle later if the following window saw no change.
- R8: `sync_out` and `sel_delayed` change only at a clock edge where `rx_tick` was high. Between receive edges they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | One-cycle pulse marking the receive clock edge |
| win_open | input | 1 | One-cycle pulse at the start of the setup part of the guard window |
| win_close | input | 1 | One-cycle pulse at the end of the hold part of the guard window |
| async_in | input | DW | Input data with no timing relation to the receive edge |
| sync_out | output | DW | Synchronized data, taken from the direct or the delayed path |
| sel_delayed | output | 1 | High while the output comes from the delayed path |

## Verification
The bench builds the block with DW=4, DEPTH=6 and two synchronizer stages. It places a receive tick every 16 fast cycles, with the window opening two cycles before the tick and closing two cycles after it. Under these values it can land a transition on every phase of the receive period. That covers both window boundaries, the cycles just outside them, and changes just before and just after the receive edge. For each placement it checks the exact receive edge at which the new value appears and whether the delayed path was used. It also exercises the case where one of four bits changes alone.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

    // Source chosen for the synchronized output.
    typedef enum logic {
        PATH_DIRECT  = 1'b0,
        PATH_DELAYED = 1'b1
    } path_e;

    // Default build values.
    localparam int unsigned DEF_DW     = 4;
    localparam int unsigned DEF_DEPTH  = 6;
    localparam int unsigned DEF_STAGES = 2;

    // Detector register state.
    typedef struct packed {
        logic armed;   // window currently open
        logic hit;     // change seen in the current window
        logic dec;     // decision taken at window close
    } det_state_t;

endpackage

// File: rtl/mwin_tapline.sv
module mwin_tapline #(
    parameter int unsigned DW    = 4,
    parameter int unsigned DEPTH = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] tap_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) tap_q[0] <= '0;
        else     tap_q[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) tap_q[i] <= '0;
            else     tap_q[i] <= tap_q[i-1];
        end
    end

    assign dout = tap_q[DEPTH-1];

endmodule

// File: rtl/mwin_sync2.sv
module mwin_sync2 #(
    parameter int unsigned DW     = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst)     stg_q[0] <= '0;
        else if (en) stg_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)     stg_q[s] <= '0;
            else if (en) stg_q[s] <= stg_q[s-1];
        end
    end

    assign dout = stg_q[STAGES-1];

    // The last stage moves only on a receive edge.
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout)); // R8

endmodule

// File: rtl/mwin_window_det.sv
module mwin_window_det
    import mwin_pkg::*;
#(
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win_open,
    input  logic          win_close,
    input  logic [DW-1:0] din,
    output logic          use_delayed
);

    logic [DW-1:0] prev_q;
    det_state_t    st_q, st_d;
    logic          moved;
    logic          in_win;
    logic          caught;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    assign moved  = |(din ^ prev_q);
    assign in_win = win_open | st_q.armed;
    assign caught = moved & in_win;

    always_comb begin
        st_d = st_q;
        st_d.armed = in_win & ~win_close;
        if (win_open) st_d.hit = caught;
        else          st_d.hit = st_q.hit | caught;
        if (win_close) st_d.dec = st_q.hit | caught;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign use_delayed = st_q.dec;

    // Strobes must be distinct pulses.
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
        !(win_open && win_close)); // R3

    // The per-window decision moves only after a window closes.
    AST_DECIDE_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(use_delayed) |-> $past(win_close)); // R7

endmodule

// File: rtl/mwin_sync_front.sv
module mwin_sync_front
    import mwin_pkg::*;
#(
    parameter int unsigned DW     = DEF_DW,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_tick,
    input  logic          win_open,
    input  logic          win_close,
    input  logic [DW-1:0] async_in,
    output logic [DW-1:0] sync_out,
    output logic          sel_delayed
);

    logic [DW-1:0] in_q;
    logic [DW-1:0] late_d;
    logic [DW-1:0] direct_s;
    logic [DW-1:0] delayed_s;
    logic          decide;
    path_e         path_q;

    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= async_in;
    end

    mwin_tapline #(.DW(DW), .DEPTH(DEPTH)) u_tap (
        .clk (clk),
        .rst (rst),
        .din (in_q),
        .dout(late_d)
    );

    mwin_sync2 #(.DW(DW), .STAGES(STAGES)) u_direct (
        .clk (clk),
        .rst (rst),
        .en  (rx_tick),
        .din (in_q),
        .dout(direct_s)
    );

    mwin_sync2 #(.DW(DW), .STAGES(STAGES)) u_delayed (
        .clk (clk),
        .rst (rst),
        .en  (rx_tick),
        .din (late_d),
        .dout(delayed_s)
    );

    mwin_window_det #(.DW(DW)) u_det (
        .clk        (clk),
        .rst        (rst),
        .win_open   (win_open),
        .win_close  (win_close),
        .din        (in_q),
        .use_delayed(decide)
    );

    always_ff @(posedge clk) begin
        if (rst)          path_q <= PATH_DIRECT;
        else if (rx_tick) path_q <= decide ? PATH_DELAYED : PATH_DIRECT;
    end

    assign sync_out    = (path_q == PATH_DELAYED) ? delayed_s : direct_s;
    assign sel_delayed = (path_q == PATH_DELAYED);

    AST_SEL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_delayed) |-> $past(rx_tick)); // R4

    AST_OUT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(sync_out) |-> $past(rx_tick)); // R8

endmodule

// File: tb/sim_mwin_sync_front.sv
module sim_mwin_sync_front;

    localparam int DW = 4;
    localparam int RX = 16;
    localparam int SU = 2;
    localparam int HO = 2;
    localparam int ANCHOR = RX - SU - 1;
    localparam int PROBE  = RX / 2;

    typedef struct {
        logic [DW-1:0] out;
        logic          sel;
        string         rq_o;
        string         rq_s;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] async_in = '0;
    logic [DW-1:0] sync_out;
    logic          sel_delayed;
    logic [3:0]    ph;
    logic          rx_tick, win_open, win_close;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb[$];
    logic [DW-1:0] cur = '0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ph <= '0;
        else     ph <= ph + 4'd1;
    end

    assign rx_tick   = !rst && (ph == 4'd0);
    assign win_open  = !rst && (ph == 4'(RX - SU));
    assign win_close = !rst && (ph == 4'(HO));

    mwin_sync_front #(.DW(DW), .DEPTH(6), .STAGES(2)) u0 (
        .clk        (clk),
        .rst        (rst),
        .rx_tick    (rx_tick),
        .win_open   (win_open),
        .win_close  (win_close),
        .async_in   (async_in),
        .sync_out   (sync_out),
        .sel_delayed(sel_delayed)
    );

    task automatic check_val(string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // Monitor: one observation per receive period, mid-period.
    always @(negedge clk) begin
        if (!rst && ph == 4'(PROBE) && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check_val(e.rq_o, sync_out, e.out);
            check_val(e.rq_s, {{(DW-1){1'b0}}, sel_delayed}, {{(DW-1){1'b0}}, e.sel});
        end
    end

    // Driver: called at a negedge where ph == ANCHOR. The change is driven
    // `off` negedges later; its detect cycle is `off` cycles after window open.
    task automatic run_event(int off, logic [DW-1:0] nv);
        bit inwin;
        exp_t e;
        inwin = (off <= SU + HO);
        e.out = cur; e.sel = 1'b0; e.rq_o = "R8 hold before edge"; e.rq_s = "R8 sel before edge";
        sb.push_back(e);
        e.out = cur; e.sel = inwin;
        e.rq_o = inwin ? "R5 delayed path old value" : "R6 direct path old value";
        e.rq_s = inwin ? "R4 sel raised (R2 R3)" : "R6 sel stays low (R3)";
        sb.push_back(e);
        e.out = nv; e.sel = 1'b0;
        e.rq_o = inwin ? "R5 new value one cycle late" : "R6 new value direct";
        e.rq_s = "R7 sel cleared";
        sb.push_back(e);
        for (int i = 0; i < 3 * RX; i++) begin
            if (i == off) async_in = nv;
            @(negedge clk);
        end
        cur = nv;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check_val("R1 out in reset", sync_out, '0);
        check_val("R1 sel in reset", {{(DW-1){1'b0}}, sel_delayed}, '0);
        rst = 1'b0;
        @(negedge clk);
        while (ph != 4'(ANCHOR)) @(negedge clk);
        run_event(0,  4'h5);  // first in-window cycle, before edge
        run_event(2,  4'hA);  // change at the receive edge
        run_event(4,  4'h2);  // last in-window cycle
        run_event(5,  4'hD);  // one past window close
        run_event(15, 4'h3);  // one before window open
        run_event(3,  4'hB);  // after edge, inside window
        run_event(1,  4'h3);  // single-bit change in window (R2)
        run_event(10, 4'h6);  // mid-period, outside window
        run_event(3,  4'h7);  // single-bit change after edge
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R8 scoreboard left %0d items expected 0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule